// File: doc/BRIEF.md
# Chained Descriptor Channel Sequencer

This block is a single channel of a work engine that walks a linked list of fixed eight-word descriptors in memory. Software points the channel at the first descriptor and then credits it with work through a counting semaphore. For every descriptor the channel reads the descriptor words over a request/grant memory port. It checks them for malformed content and hands the transfer fields to a processing engine through a start/done handshake. When the engine succeeds, the channel stores a completion word back into the descriptor. It then pulses an interrupt if asked to and moves on along the next pointer.

Each descriptor carries its own control over whether the chain continues, whether the interrupt fires and whether the semaphore is consumed. A ring of descriptors can therefore be fed forever by software that adds credits. Any error stops the channel, records the cause in a channel status word and raises the interrupt without writing the descriptor's completion word.

Top module: `chain_chan_seq`

## Requirements
- R1: Descriptors are eight words at byte offsets 0 (next), 4 (control A), 8 (control B), 12 (source), 16 (destination), 20 (byte count), 24 (payload pointer) and 28 (status), starting at the command pointer. At engine start, `eng_src`, `eng_dst`, `eng_len`, `eng_ctrl0`, `eng_ctrl1` and `eng_key_ptr` equal the fetched words, and `eng_start` is a one-cycle pulse.
- R2: A semaphore write adds its value to `sema_count`, saturating at the all-ones value. The channel fetches nothing while the count is zero. `sema_count` is zero after reset.
- R3: Control A bit 1 set decrements `sema_count` by one when the descriptor completes successfully. When the bit is clear, the count is untouched.
- R4: Control A bit 2 set makes the channel load the next pointer and continue, so circular rings are legal. When it is clear, the channel goes idle (`busy`=0) after the descriptor, even with credits left.
- R5: On success the channel writes the value 1 to the descriptor's status word (offset 28). That write is granted before the interrupt pulse.
- R6: Control A bit 0 set gives a one-cycle `irq` pulse after success. When it is clear, success raises no interrupt.
- R7: A byte count that is not a multiple of 16 sets channel status bit 2 (setup error), and the engine is not started.
- R8: Control A bit 2 set with a next pointer of zero gives error code 1 in channel status bits 19:16.
- R9: Control A bit 5 (cipher on) together with both key selects (bits 10 and 11) gives error code 5 in bits 19:16. This code takes priority over code 1. Bits 8 and 9 and control B bit 4 pass to the engine unchanged.
- R10: An engine completion with `eng_fail` set sets channel status bit 3 (packet error).
- R11: After any error the channel goes idle, leaves the descriptor status word unwritten, keeps `sema_count`, and pulses `irq` once whatever control A bit 0 says.
- R12: A command pointer write is taken only while idle or waiting for credits. It clears channel status and restarts fetching at the new address.
- R13: A memory request that is not granted keeps `mem_req`, `mem_we` and `mem_addr` stable until granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr_en | input | 1 | Command pointer write strobe |
| ptr_wr_addr | input | ADDR_W | Byte address of first descriptor |
| sema_wr_en | input | 1 | Semaphore credit write strobe |
| sema_wr_val | input | SEMA_W | Credits to add |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | DATA_W | Read data |
| eng_start | output | 1 | Engine start pulse |
| eng_ctrl0 | output | DATA_W | Control A word |
| eng_ctrl1 | output | DATA_W | Control B word |
| eng_src | output | DATA_W | Source address |
| eng_dst | output | DATA_W | Destination address |
| eng_len | output | DATA_W | Byte count |
| eng_key_ptr | output | DATA_W | Payload pointer |
| eng_done | input | 1 | Engine finished |
| eng_fail | input | 1 | Engine finished with an error |
| irq | output | 1 | Interrupt pulse |
| busy | output | 1 | Channel not idle |
| sema_count | output | SEMA_W | Outstanding credits |
| chan_status | output | DATA_W | Error code and flags |

## Verification
The hardest state to reach from the ports is a ring that wraps back to its first descriptor and only moves there because a fresh credit arrives. The stimulus builds a three-entry circular ring, grants exactly three credits, and checks that the channel parks waiting on the fourth fetch. It then resets the completion words in memory and adds one credit, which must revisit only the first descriptor. Errors are reached by planting malformed descriptors (unaligned count, zero next pointer with chaining, conflicting key selects) and by making the engine model report failure. Memory grants follow a pseudo-random pattern so that stalled requests occur throughout.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_WAIT, ST_FETCH, ST_CHECK, ST_START,
      ST_RUN, ST_WB, ST_NOTE, ST_ERR
   } chan_state_t;

   localparam int unsigned DESC_WORDS  = 8;
   localparam int unsigned FETCH_WORDS = 7;

   // word order inside a descriptor (neighbours decode this layout)
   localparam int unsigned W_NEXT = 0;
   localparam int unsigned W_CTLA = 1;
   localparam int unsigned W_CTLB = 2;
   localparam int unsigned W_SRC  = 3;
   localparam int unsigned W_DST  = 4;
   localparam int unsigned W_LEN  = 5;
   localparam int unsigned W_KEY  = 6;
   localparam int unsigned W_STAT = 7;

   // control A bit positions
   localparam int unsigned CA_IRQ    = 0;
   localparam int unsigned CA_DEC    = 1;
   localparam int unsigned CA_CHAIN  = 2;
   localparam int unsigned CA_CIPHER = 5;
   localparam int unsigned CA_HWKEY  = 10;
   localparam int unsigned CA_PAYKEY = 11;

   // channel status layout
   localparam int unsigned SC_CODE_LSB   = 16;
   localparam int unsigned SC_FLAG_SETUP = 2;
   localparam int unsigned SC_FLAG_PKT   = 3;
   localparam logic [3:0]  CODE_NONE     = 4'd0;
   localparam logic [3:0]  CODE_NEXT0    = 4'd1;
   localparam logic [3:0]  CODE_BADMODE  = 4'd5;
endpackage

// File: rtl/chain_seq_sema.sv
module chain_seq_sema #(
   parameter int unsigned SEMA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              add_en,
   input  logic [SEMA_W-1:0] add_val,
   input  logic              dec_en,
   output logic [SEMA_W-1:0] count
);
   localparam logic [SEMA_W:0] SAT = {1'b0, {SEMA_W{1'b1}}};

   logic [SEMA_W:0]   sum;
   logic [SEMA_W-1:0] capped;
   logic [SEMA_W-1:0] nxt;

   always_comb begin
      sum    = {1'b0, count} + (add_en ? {1'b0, add_val} : '0);
      capped = (sum > SAT) ? SAT[SEMA_W-1:0] : sum[SEMA_W-1:0];
      nxt    = (dec_en && capped != '0) ? capped - 1'b1 : capped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end
endmodule

// File: rtl/chain_seq_desc_regs.sv
module chain_seq_desc_regs #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 7,
   parameter int unsigned IDX_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_en,
   input  logic [IDX_W-1:0]              cap_idx,
   input  logic [DATA_W-1:0]             cap_data,
   output logic [NWORDS-1:0][DATA_W-1:0] words
);
   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= '0;
         else if (cap_en && cap_idx == IDX_W'(g))
            words[g] <= cap_data;
      end
   end
endmodule

// File: rtl/chain_seq_validate.sv
module chain_seq_validate
   import chain_seq_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BLK_BYTES = 16
) (
   input  logic              cipher_on,
   input  logic              hw_key,
   input  logic              pay_key,
   input  logic              chain_on,
   input  logic [DATA_W-1:0] next_ptr,
   input  logic [DATA_W-1:0] byte_len,
   output logic              err,
   output logic [DATA_W-1:0] err_word
);
   logic       misalign;
   logic [3:0] code;

   if (BLK_BYTES <= 1) begin : g_noalign
      logic unused_len;
      assign unused_len = ^byte_len;
      assign misalign   = 1'b0;
   end else begin : g_align
      assign misalign = (byte_len & DATA_W'(BLK_BYTES - 1)) != '0;
   end

   always_comb begin
      if (cipher_on && hw_key && pay_key)   code = CODE_BADMODE;
      else if (chain_on && next_ptr == '0)  code = CODE_NEXT0;
      else                                  code = CODE_NONE;
      err_word = '0;
      err_word[SC_CODE_LSB +: 4] = code;
      err_word[SC_FLAG_SETUP]    = misalign;
      err = misalign || (code != CODE_NONE);
   end
endmodule

// File: rtl/chain_chan_seq.sv
module chain_chan_seq
   import chain_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SEMA_W    = 8,
   parameter int unsigned BLK_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr_en,
   input  logic [ADDR_W-1:0] ptr_wr_addr,
   input  logic              sema_wr_en,
   input  logic [SEMA_W-1:0] sema_wr_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              eng_start,
   output logic [DATA_W-1:0] eng_ctrl0,
   output logic [DATA_W-1:0] eng_ctrl1,
   output logic [DATA_W-1:0] eng_src,
   output logic [DATA_W-1:0] eng_dst,
   output logic [DATA_W-1:0] eng_len,
   output logic [DATA_W-1:0] eng_key_ptr,
   input  logic              eng_done,
   input  logic              eng_fail,
   output logic              irq,
   output logic              busy,
   output logic [SEMA_W-1:0] sema_count,
   output logic [DATA_W-1:0] chan_status
);
   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
   localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(W_STAT * WORD_BYTES);
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FETCH_WORDS - 1);

   if (DATA_W < 20 || DATA_W % 8 != 0) begin : g_bad_data_w
      $error("DATA_W must be a byte multiple of at least 20 bits");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must not exceed DATA_W");
   end
   if (SEMA_W < 1) begin : g_bad_sema_w
      $error("SEMA_W must be at least 1");
   end
   if ((BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end

   chan_state_t                    state;
   logic [ADDR_W-1:0]              ptr;
   logic [IDX_W-1:0]               idx;
   logic [FETCH_WORDS-1:0][DATA_W-1:0] words;
   logic                           chk_err;
   logic [DATA_W-1:0]              chk_word;
   logic                           sema_dec;
   logic                           ptr_take;
   logic [DATA_W-1:0]              pkt_err_word;

   chain_seq_sema #(.SEMA_W(SEMA_W)) sema_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (sema_wr_en),
      .add_val (sema_wr_val),
      .dec_en  (sema_dec),
      .count   (sema_count)
   );

   chain_seq_desc_regs #(.DATA_W(DATA_W), .NWORDS(FETCH_WORDS), .IDX_W(IDX_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (state == ST_FETCH && mem_gnt),
      .cap_idx  (idx),
      .cap_data (mem_rdata),
      .words    (words)
   );

   chain_seq_validate #(.DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES)) val_i (
      .cipher_on (words[W_CTLA][CA_CIPHER]),
      .hw_key    (words[W_CTLA][CA_HWKEY]),
      .pay_key   (words[W_CTLA][CA_PAYKEY]),
      .chain_on  (words[W_CTLA][CA_CHAIN]),
      .next_ptr  (words[W_NEXT]),
      .byte_len  (words[W_LEN]),
      .err       (chk_err),
      .err_word  (chk_word)
   );

   always_comb begin
      pkt_err_word = '0;
      pkt_err_word[SC_FLAG_PKT] = 1'b1;
   end

   assign ptr_take  = ptr_wr_en && (state == ST_IDLE || state == ST_WAIT);
   assign sema_dec  = (state == ST_NOTE) && words[W_CTLA][CA_DEC];
   assign mem_req   = (state == ST_FETCH) || (state == ST_WB);
   assign mem_we    = (state == ST_WB);
   assign mem_addr  = (state == ST_WB) ? ptr + STAT_OFS
                                       : ptr + ADDR_W'(idx) * ADDR_W'(WORD_BYTES);
   assign mem_wdata = (state == ST_WB) ? DATA_W'(1) : '0;
   assign eng_start = (state == ST_START);
   assign irq       = (state == ST_ERR) ||
                      ((state == ST_NOTE) && words[W_CTLA][CA_IRQ]);
   assign busy      = (state != ST_IDLE);

   assign eng_ctrl0   = words[W_CTLA];
   assign eng_ctrl1   = words[W_CTLB];
   assign eng_src     = words[W_SRC];
   assign eng_dst     = words[W_DST];
   assign eng_len     = words[W_LEN];
   assign eng_key_ptr = words[W_KEY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         ptr         <= '0;
         idx         <= '0;
         chan_status <= '0;
      end else if (ptr_take) begin
         ptr         <= ptr_wr_addr;
         chan_status <= '0;
         state       <= ST_WAIT;
      end else begin
         unique case (state)
            ST_IDLE: state <= ST_IDLE;
            ST_WAIT: begin
               if (sema_count != '0) begin
                  idx   <= '0;
                  state <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_gnt) begin
                  if (idx == LAST_IDX) state <= ST_CHECK;
                  else                 idx   <= idx + 1'b1;
               end
            end
            ST_CHECK: begin
               if (chk_err) begin
                  chan_status <= chk_word;
                  state       <= ST_ERR;
               end else begin
                  state <= ST_START;
               end
            end
            ST_START: state <= ST_RUN;
            ST_RUN: begin
               if (eng_done) begin
                  if (eng_fail) begin
                     chan_status <= pkt_err_word;
                     state       <= ST_ERR;
                  end else begin
                     state <= ST_WB;
                  end
               end
            end
            ST_WB: if (mem_gnt) state <= ST_NOTE;
            ST_NOTE: begin
               if (words[W_CTLA][CA_CHAIN]) begin
                  ptr   <= words[W_NEXT][ADDR_W-1:0];
                  state <= ST_WAIT;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_ERR:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/chain_chan_seq_chk.sv
module chain_chan_seq_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEMA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              eng_start,
   input logic              irq,
   input logic              busy,
   input logic [SEMA_W-1:0] sema_count,
   input logic [DATA_W-1:0] chan_status
);
   assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   assert_start_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (sema_count != '0));

   assert_irq_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !mem_req);

   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !eng_start));

   assert_err_no_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_status != '0) |-> !(mem_req && mem_we));
endmodule

bind chain_chan_seq chain_chan_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEMA_W(SEMA_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_gnt     (mem_gnt),
   .mem_addr    (mem_addr),
   .eng_start   (eng_start),
   .irq         (irq),
   .busy        (busy),
   .sema_count  (sema_count),
   .chan_status (chan_status)
);

// File: tb/chain_chan_seq_tb_top.sv
module chain_chan_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ptr_wr_en;
   logic [31:0] ptr_wr_addr;
   logic        sema_wr_en;
   logic [7:0]  sema_wr_val;
   logic        mem_req, mem_we, mem_gnt;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        eng_start;
   logic [31:0] eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_len, eng_key_ptr;
   logic        eng_done, eng_fail;
   logic        irq, busy;
   logic [7:0]  sema_count;
   logic [31:0] chan_status;

   logic [31:0] mem [0:255];
   logic [7:0]  lfsr;
   logic        gnt_ok;
   logic        eng_pend;
   logic [3:0]  eng_cnt;
   logic        fail_mode;

   int checks = 0;
   int fails  = 0;
   int starts = 0;
   int irqs   = 0;
   int reqs   = 0;
   int unsigned last_desc = 0;
   int unsigned exp_q[$];

   always #10 clk = ~clk;

   chain_chan_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .ptr_wr_en(ptr_wr_en), .ptr_wr_addr(ptr_wr_addr),
      .sema_wr_en(sema_wr_en), .sema_wr_val(sema_wr_val),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .eng_start(eng_start), .eng_ctrl0(eng_ctrl0), .eng_ctrl1(eng_ctrl1),
      .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len),
      .eng_key_ptr(eng_key_ptr), .eng_done(eng_done), .eng_fail(eng_fail),
      .irq(irq), .busy(busy), .sema_count(sema_count), .chan_status(chan_status)
   );

   // memory model: grant pattern from an LFSR, read data combinational
   assign mem_gnt   = mem_req && gnt_ok;
   assign mem_rdata = mem[mem_addr[9:2]];
   assign eng_fail  = eng_done && fail_mode;

   always @(negedge clk) begin
      if (!rst_n) lfsr <= 8'h5A;
      else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      gnt_ok <= lfsr[0] | lfsr[3];
   end

   always @(posedge clk)
      if (mem_req && mem_we && mem_gnt) mem[mem_addr[9:2]] <= mem_wdata;

   // engine model: done a few cycles after start
   always @(posedge clk) begin
      if (!rst_n) begin
         eng_done <= 1'b0; eng_pend <= 1'b0; eng_cnt <= 4'd0;
      end else begin
         eng_done <= 1'b0;
         if (eng_start) begin
            eng_pend <= 1'b1; eng_cnt <= 4'd4;
         end else if (eng_pend) begin
            if (eng_cnt == 0) begin eng_done <= 1'b1; eng_pend <= 1'b0; end
            else eng_cnt <= eng_cnt - 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference monitor, evaluated every clock away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req) reqs++;
         if (eng_start) begin
            starts++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1 unexpected engine start", 32'd1, 32'd0);
            end else begin
               int unsigned a;
               a = exp_q.pop_front();
               last_desc = a;
               a = a >> 2;
               chk(eng_src     == mem[a+3], "R1 src field",     eng_src,     mem[a+3]);
               chk(eng_dst     == mem[a+4], "R1 dst field",     eng_dst,     mem[a+4]);
               chk(eng_len     == mem[a+5], "R1 len field",     eng_len,     mem[a+5]);
               chk(eng_ctrl0   == mem[a+1], "R9 ctrl A passed", eng_ctrl0,   mem[a+1]);
               chk(eng_ctrl1   == mem[a+2], "R9 ctrl B passed", eng_ctrl1,   mem[a+2]);
               chk(eng_key_ptr == mem[a+6], "R1 payload field", eng_key_ptr, mem[a+6]);
            end
         end
         if (mem_req && mem_we)
            chk(mem_addr == last_desc + 28 && mem_wdata == 32'd1,
                "R5 write-back target", mem_addr, last_desc + 28);
         if (irq) begin
            irqs++;
            if (chan_status == 0)
               chk(mem[(last_desc >> 2) + 7] == 32'd1, "R5 status stored before irq",
                   mem[(last_desc >> 2) + 7], 32'd1);
         end
      end
   end

   task automatic make_desc(input int unsigned base, input logic [31:0] nxt,
                            input logic [31:0] ca, input logic [31:0] cb,
                            input logic [31:0] len);
      int unsigned w;
      w = base >> 2;
      mem[w]   = nxt;
      mem[w+1] = ca;
      mem[w+2] = cb;
      mem[w+3] = 32'h1000_0000 + base;
      mem[w+4] = 32'h2000_0000 + base;
      mem[w+5] = len;
      mem[w+6] = 32'h3000_0000 + base;
      mem[w+7] = 32'hDEAD_BEEF;
   endtask

   task automatic wr_ptr(input logic [31:0] a);
      @(negedge clk); ptr_wr_en = 1'b1; ptr_wr_addr = a;
      @(negedge clk); ptr_wr_en = 1'b0;
   endtask

   task automatic wr_sema(input logic [7:0] v);
      @(negedge clk); sema_wr_en = 1'b1; sema_wr_val = v;
      @(negedge clk); sema_wr_en = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   end

   initial begin
      int s0, i0, r0;
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      rst_n = 1'b0; ptr_wr_en = 1'b0; ptr_wr_addr = '0;
      sema_wr_en = 1'b0; sema_wr_val = '0; fail_mode = 1'b0;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(1);
      // reset state
      chk(busy == 0 && irq == 0 && mem_req == 0, "R2 reset outputs quiet",
          {busy, irq, mem_req}, 0);
      chk(sema_count == 0, "R2 reset count", sema_count, 0);
      chk(chan_status == 0, "R12 reset status", chan_status, 0);

      // circular ring A -> B -> C -> A
      make_desc(32'h40, 32'h80, 32'h827, 32'h0,  32'd32);
      make_desc(32'h80, 32'hC0, 32'h827, 32'h10, 32'd48);
      make_desc(32'hC0, 32'h40, 32'h827, 32'h0,  32'd16);
      wr_ptr(32'h40);
      r0 = reqs;
      wait_cyc(40);
      chk(reqs == r0, "R2 no fetch without credit", reqs, r0);
      exp_q.push_back(32'h40); exp_q.push_back(32'h80); exp_q.push_back(32'hC0);
      wr_sema(8'd3);
      wait_cyc(400);
      chk(starts == 3, "R4 ring walked three entries", starts, 3);
      chk(irqs == 3, "R6 one pulse per entry", irqs, 3);
      chk(mem[16+7] == 1 && mem[32+7] == 1 && mem[48+7] == 1,
          "R5 completion words", {mem[16+7][7:0], mem[32+7][7:0], mem[48+7][7:0]}, 32'h010101);
      chk(sema_count == 0, "R3 credits consumed", sema_count, 0);
      chk(busy == 1, "R4 parked waiting for credit", busy, 1);
      mem[16+7] = 32'hDEAD_BEEF; mem[32+7] = 32'hDEAD_BEEF;
      exp_q.push_back(32'h40);
      wr_sema(8'd1);
      wait_cyc(150);
      chk(starts == 4, "R4 ring wrapped to first entry", starts, 4);
      chk(mem[16+7] == 1 && mem[32+7] == 32'hDEAD_BEEF, "R2 one credit one entry",
          mem[32+7], 32'hDEAD_BEEF);

      // unchained descriptor with decrement, hardware key; channel stops
      make_desc(32'h100, 32'h140, 32'h423, 32'h0, 32'd64);
      wr_ptr(32'h100);
      exp_q.push_back(32'h100);
      wr_sema(8'd5);
      wait_cyc(200);
      chk(starts == 5, "R4 single entry run", starts, 5);
      chk(busy == 0, "R4 idle after unchained entry", busy, 0);
      chk(sema_count == 4, "R3 one credit taken", sema_count, 4);

      // no decrement, no interrupt request
      make_desc(32'h140, 32'h0, 32'h020, 32'h0, 32'd16);
      i0 = irqs;
      exp_q.push_back(32'h140);
      wr_ptr(32'h140);
      wait_cyc(150);
      chk(mem[80+7] == 1, "R5 completion without irq", mem[80+7], 1);
      chk(sema_count == 4, "R3 count kept when bit clear", sema_count, 4);
      chk(irqs == i0, "R6 silent completion", irqs, i0);

      // saturating credits while idle
      wr_sema(8'd255);
      wait_cyc(3);
      chk(sema_count == 8'hFF, "R2 saturation", sema_count, 8'hFF);

      // unaligned length
      make_desc(32'h180, 32'h0, 32'h020, 32'h0, 32'd20);
      s0 = starts; i0 = irqs;
      wr_ptr(32'h180);
      wait_cyc(100);
      chk(chan_status == 32'h4, "R7 setup flag", chan_status, 32'h4);
      chk(starts == s0, "R7 engine not started", starts, s0);
      chk(irqs == i0 + 1, "R11 irq forced on error", irqs, i0 + 1);
      chk(mem[96+7] == 32'hDEAD_BEEF && busy == 0, "R11 halted, word untouched",
          mem[96+7], 32'hDEAD_BEEF);

      // chaining into a zero pointer
      make_desc(32'h1C0, 32'h0, 32'h027, 32'h0, 32'd16);
      wr_ptr(32'h1C0);
      wait_cyc(100);
      chk(chan_status == 32'h1_0000, "R8 next-zero code", chan_status, 32'h1_0000);

      // both key selects with cipher on (also chained to zero: code 5 wins)
      make_desc(32'h200, 32'h0, 32'hC25, 32'h0, 32'd16);
      wr_ptr(32'h200);
      wait_cyc(100);
      chk(chan_status == 32'h5_0000, "R9 bad-mode code", chan_status, 32'h5_0000);
      chk(sema_count == 8'hFF, "R11 credits kept on error", sema_count, 8'hFF);

      // engine failure
      make_desc(32'h240, 32'h0, 32'h323, 32'h10, 32'd32);
      fail_mode = 1'b1;
      exp_q.push_back(32'h240);
      i0 = irqs;
      wr_ptr(32'h240);
      wait_cyc(150);
      chk(chan_status == 32'h8, "R10 packet flag", chan_status, 32'h8);
      chk(mem[144+7] == 32'hDEAD_BEEF, "R11 no store after engine error",
          mem[144+7], 32'hDEAD_BEEF);
      chk(irqs == i0 + 1 && sema_count == 8'hFF, "R11 irq once, credits kept",
          irqs, i0 + 1);
      fail_mode = 1'b0;

      // new pointer clears status
      make_desc(32'h280, 32'h0, 32'h020, 32'h0, 32'd64);
      exp_q.push_back(32'h280);
      wr_ptr(32'h280);
      chk(chan_status == 0, "R12 status cleared by pointer write", chan_status, 0);
      wait_cyc(150);
      chk(mem[160+7] == 1 && busy == 0, "R12 restarted at new address", mem[160+7], 1);
      chk(exp_q.size() == 0, "R1 all expected starts seen", exp_q.size(), 0);

      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   end
endmodule